// File: doc/BRIEF.md
# Local Memory Bus Cycle Sequencer

This block turns single memory requests into fixed-length local-bus cycles for a communications processor's private memory. Each accepted request becomes one cycle of exactly sixteen clocks, and each clock is one phase slot. From the slot number and the request, the block drives a multiplexed row/column address and the DRAM strobes: row strobe, column strobe, output enable and write strobe. It also drives a ROM chip select, a refresh indicator, a data-direction line for external bidirectional buffers and a reset line for the glue logic on the bus.

The address is decoded into three regions. The identity ROM occupies 0x000000–0x00000F. When the boot flag is 0, the boot ROM covers 0x000010–0x00FFFF and 0x1F0000–0x1FFFFF. Every other address is DRAM, and so are the boot ROM ranges when the boot flag is 1. The column strobe and the output enable stay inactive outside DRAM. A refresh request runs a column-before-row refresh at an address taken from an internal counter.

Requests use a valid/ready handshake. They are taken only when the bus is idle or in the last slot of a cycle, so cycles can run back to back with no gap.

Top module: `lmb_seq`

## Requirements
- R1: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the bus is idle or in slot 15. The accepted cycle runs slots 0 to 15, one per clock, starting the clock after acceptance. `done` is high exactly during slot 15.
- R2: In an access cycle, `ma` carries the row (address bits 20:11, zero-extended to 11 bits) in slots 0–4 and the column (address bits 10:0) in slots 5–15.
- R3: In an access cycle, `ras_n` is low in slots 0–4 and high otherwise. In a refresh cycle, it is low in slots 1–5.
- R4: Addresses 0x000000–0x00000F are the identity ROM. `cas_n` is low in slots 5–7 of an access cycle only when the address decodes as DRAM.
- R5: With `boot_mode`=0, addresses 0x000010–0x00FFFF and 0x1F0000–0x1FFFFF are boot ROM and keep `cas_n` high. With `boot_mode`=1, these addresses are DRAM.
- R6: In a refresh cycle, `cas_n` is low in slots 0–4 and `refresh` is high in all 16 slots. `ma` carries the refresh counter zero-extended, and the counter starts at 0 after reset and increments by one after each refresh cycle. The request address, write flag and boot flag have no effect on a refresh cycle.
- R7: In slots 0–3 of an access cycle, `rom_sel_n` is low only for a read that decodes as boot ROM. In slots 4–15, it carries address bit 13. It is high in refresh cycles and when idle.
- R8: `oe_n` is low in slots 5–15 of a read that decodes as DRAM, and high in all other cases.
- R9: `dir` is 1 for all 16 slots of a write access and 0 otherwise. `we_n` is low in slots 5–15 of a write access and high otherwise.
- R10: `bus_rst_n` goes low one clock after `rst` or `sw_reset` is high. It goes high one clock after both are low.
- R11: When idle, `ras_n`, `cas_n`, `oe_n`, `we_n` and `rom_sel_n` are high, and `refresh`, `dir`, `done` and `ma` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also the external system reset |
| sw_reset | input | 1 | Software reset request for bus glue logic |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this clock |
| req_addr | input | 21 | Byte address of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_refresh | input | 1 | 1 = refresh cycle |
| boot_mode | input | 1 | 0 = ROM ranges mapped to boot ROM |
| done | output | 1 | High during the last slot of a cycle |
| ma | output | 11 | Multiplexed row/column or refresh address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| oe_n | output | 1 | DRAM output enable, active low |
| we_n | output | 1 | Write strobe, active low |
| rom_sel_n | output | 1 | ROM select in slots 0–3, address bit 13 afterwards |
| refresh | output | 1 | Refresh cycle in progress |
| dir | output | 1 | Buffer direction, 1 = write |
| bus_rst_n | output | 1 | Bus glue-logic reset, active low |

## Verification
The bench builds the block with its default parameters: an 11-bit multiplexed address and an 8-bit refresh counter. With these values, every region edge lies in the 21-bit map (0x00000F/0x000010, 0x00FFFF/0x010000, 0x1EFFFF/0x1F0000, 0x1FFFFF), and each edge is run under both boot flag values. Back-to-back cycles, idle gaps and refresh cycles with junk write and address fields are mixed in random order. The bench compares every output in every slot against its own model of the slot table and tracks the refresh count separately.

// File: rtl/lmb_pkg.sv
package lmb_pkg;
    localparam int ADDR_W   = 21;
    localparam int SLOT_W   = 4;
    localparam int SEL_BIT  = 13;
    localparam logic [SLOT_W-1:0] SEL_LAST = 4'd3;
    localparam logic [SLOT_W-1:0] ROW_LAST = 4'd4;
    localparam logic [SLOT_W-1:0] COL_LAST = 4'd7;
    localparam logic [SLOT_W-1:0] END_SLOT = 4'd15;

    localparam logic [ADDR_W-1:0] IDENT_TOP = 21'h00000F;
    localparam logic [ADDR_W-1:0] LOROM_TOP = 21'h00FFFF;
    localparam logic [ADDR_W-1:0] HIROM_BOT = 21'h1F0000;

    typedef enum logic [1:0] {
        RG_IDENT = 2'd0,
        RG_BOOT  = 2'd1,
        RG_DRAM  = 2'd2
    } region_e;

    typedef struct packed {
        logic              refresh;
        logic              write;
        region_e           region;
        logic [ADDR_W-1:0] addr;
    } cyc_t;

    function automatic region_e region_of(input logic [ADDR_W-1:0] a, input logic boot);
        if (a <= IDENT_TOP)
            return RG_IDENT;
        else if (!boot && (a <= LOROM_TOP || a >= HIROM_BOT))
            return RG_BOOT;
        else
            return RG_DRAM;
    endfunction
endpackage

// File: rtl/lmb_decode.sv
module lmb_decode
    import lmb_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              boot,
    input  logic              write,
    input  logic              refresh,
    output cyc_t              nxt
);
    always_comb begin
        nxt.refresh = refresh;
        nxt.write   = write & ~refresh;
        nxt.region  = region_of(addr, boot);
        nxt.addr    = addr;
    end
endmodule

// File: rtl/lmb_phase.sv
module lmb_phase
    import lmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  cyc_t              nxt,
    output logic              req_ready,
    output logic              busy,
    output logic              done,
    output logic [SLOT_W-1:0] slot,
    output cyc_t              cur
);
    logic accept;

    assign req_ready = ~busy | (slot == END_SLOT);
    assign accept    = req_valid & req_ready;
    assign done      = busy & (slot == END_SLOT);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            slot <= '0;
            cur  <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            slot <= '0;
            cur  <= nxt;
        end else if (busy) begin
            if (slot == END_SLOT) begin
                busy <= 1'b0;
                slot <= '0;
            end else begin
                slot <= slot + SLOT_W'(1);
            end
        end
    end

    assert_len_R1: assert property (@(posedge clk) disable iff (rst)
        (busy && slot != END_SLOT) |=> (busy && slot == $past(slot) + SLOT_W'(1)));
    assert_start_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (busy && slot == '0));
endmodule

// File: rtl/lmb_refresh_ctr.sv
module lmb_refresh_ctr #(
    parameter int REF_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [REF_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (step)
            cnt <= cnt + REF_W'(1);
    end

    assert_ref_step_R6: assert property (@(posedge clk) disable iff (rst)
        step |=> (cnt == $past(cnt) + REF_W'(1)));
    assert_ref_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(cnt));
endmodule

// File: rtl/lmb_strobe.sv
module lmb_strobe
    import lmb_pkg::*;
#(
    parameter int MA_W  = 11,
    parameter int REF_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic [SLOT_W-1:0] slot,
    input  cyc_t              cur,
    input  logic [REF_W-1:0]  refcnt,
    output logic [MA_W-1:0]   ma,
    output logic              ras_n,
    output logic              cas_n,
    output logic              oe_n,
    output logic              we_n,
    output logic              rom_sel_n,
    output logic              refresh,
    output logic              dir
);
    logic            in_row;
    logic            in_col;
    logic            is_dram;
    logic [MA_W-1:0] row_a;
    logic [MA_W-1:0] col_a;

    assign in_row  = slot <= ROW_LAST;
    assign in_col  = (slot > ROW_LAST) && (slot <= COL_LAST);
    assign is_dram = cur.region == RG_DRAM;
    assign row_a   = MA_W'(cur.addr >> MA_W);
    assign col_a   = cur.addr[MA_W-1:0];

    always_comb begin
        ma        = '0;
        ras_n     = 1'b1;
        cas_n     = 1'b1;
        oe_n      = 1'b1;
        we_n      = 1'b1;
        rom_sel_n = 1'b1;
        refresh   = 1'b0;
        dir       = 1'b0;
        if (busy) begin
            if (cur.refresh) begin
                refresh = 1'b1;
                ma      = MA_W'(refcnt);
                cas_n   = ~in_row;
                ras_n   = ~((slot >= 4'd1) && (slot <= ROW_LAST + 4'd1));
            end else begin
                ma        = in_row ? row_a : col_a;
                ras_n     = ~in_row;
                cas_n     = ~(is_dram && in_col);
                oe_n      = ~(is_dram && !cur.write && !in_row);
                we_n      = ~(cur.write && !in_row);
                dir       = cur.write;
                rom_sel_n = (slot <= SEL_LAST) ? ~((cur.region == RG_BOOT) && !cur.write)
                                               : cur.addr[SEL_BIT];
            end
        end
    end

    assert_oe_we_R8: assert property (@(posedge clk) disable iff (rst)
        !(!oe_n && !we_n));
    assert_cas_rom_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && !cur.refresh && cur.region != RG_DRAM) |-> cas_n);
    assert_ras_cas_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && !cur.refresh) |-> (ras_n || cas_n));
    assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ras_n && cas_n && oe_n && we_n && rom_sel_n && !refresh && !dir));
endmodule

// File: rtl/lmb_seq.sv
module lmb_seq
    import lmb_pkg::*;
#(
    parameter int MA_W  = 11,
    parameter int REF_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_reset,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_refresh,
    input  logic              boot_mode,
    output logic              done,
    output logic [MA_W-1:0]   ma,
    output logic              ras_n,
    output logic              cas_n,
    output logic              oe_n,
    output logic              we_n,
    output logic              rom_sel_n,
    output logic              refresh,
    output logic              dir,
    output logic              bus_rst_n
);
    cyc_t              nxt;
    cyc_t              cur;
    logic              busy;
    logic [SLOT_W-1:0] slot;
    logic [REF_W-1:0]  refcnt;

    lmb_decode u_dec (
        .addr    (req_addr),
        .boot    (boot_mode),
        .write   (req_write),
        .refresh (req_refresh),
        .nxt     (nxt)
    );

    lmb_phase u_phase (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .nxt       (nxt),
        .req_ready (req_ready),
        .busy      (busy),
        .done      (done),
        .slot      (slot),
        .cur       (cur)
    );

    lmb_refresh_ctr #(.REF_W(REF_W)) u_ref (
        .clk  (clk),
        .rst  (rst),
        .step (done & cur.refresh),
        .cnt  (refcnt)
    );

    lmb_strobe #(.MA_W(MA_W), .REF_W(REF_W)) u_strb (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .slot      (slot),
        .cur       (cur),
        .refcnt    (refcnt),
        .ma        (ma),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .rom_sel_n (rom_sel_n),
        .refresh   (refresh),
        .dir       (dir)
    );

    always_ff @(posedge clk) begin
        if (rst)
            bus_rst_n <= 1'b0;
        else
            bus_rst_n <= ~sw_reset;
    end

    assert_busrst_R10: assert property (@(posedge clk) disable iff (rst)
        sw_reset |=> !bus_rst_n);
    assert_refresh_len_R6: assert property (@(posedge clk) disable iff (rst)
        (refresh && !done) |=> refresh);
endmodule

// File: tb/sim_lmb_seq.sv
module sim_lmb_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_reset = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [20:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_refresh = 1'b0;
    logic        boot_mode = 1'b0;
    logic        done;
    logic [10:0] ma;
    logic        ras_n, cas_n, oe_n, we_n, rom_sel_n, refresh, dir, bus_rst_n;

    int errors = 0;
    int checks = 0;
    int refc   = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    lmb_seq u0 (
        .clk(clk), .rst(rst), .sw_reset(sw_reset),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_refresh(req_refresh), .boot_mode(boot_mode),
        .done(done), .ma(ma), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n),
        .we_n(we_n), .rom_sel_n(rom_sel_n), .refresh(refresh), .dir(dir),
        .bus_rst_n(bus_rst_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    // 0 = identity ROM, 1 = boot ROM, 2 = DRAM
    function automatic int region(input int a, input bit b);
        if (a <= 'h0F) return 0;
        if (!b && (a <= 'hFFFF || a >= 'h1F0000)) return 1;
        return 2;
    endfunction

    task automatic check_idle(input string why);
        chk({"R11 ras_n ", why}, ras_n, 1);
        chk({"R11 cas_n ", why}, cas_n, 1);
        chk({"R11 oe_n ", why}, oe_n, 1);
        chk({"R11 we_n ", why}, we_n, 1);
        chk({"R11 rom_sel_n ", why}, rom_sel_n, 1);
        chk({"R11 refresh ", why}, refresh, 0);
        chk({"R11 dir ", why}, dir, 0);
        chk({"R11 ma ", why}, ma, 0);
        chk({"R1 done idle ", why}, done, 0);
        chk({"R1 ready idle ", why}, req_ready, 1);
    endtask

    // Called at a negedge where the design is ready; returns at the negedge of slot 15.
    task automatic run_cycle(input int a, input bit w, input bit r, input bit b);
        int  rg;
        bit  dram;
        chk("R1 ready before accept", req_ready, 1);
        req_addr = a[20:0]; req_write = w; req_refresh = r; boot_mode = b;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr = $urandom; req_write = $urandom; boot_mode = $urandom;
        rg   = region(a, b);
        dram = (rg == 2);
        for (int s = 0; s < 16; s++) begin
            if (r) begin
                chk("R6 ma refresh", ma, refc);
                chk("R3 ras_n refresh", ras_n, (s >= 1 && s <= 5) ? 0 : 1);
                chk("R6 cas_n refresh", cas_n, (s <= 4) ? 0 : 1);
                chk("R6 refresh flag", refresh, 1);
                chk("R6 oe_n refresh", oe_n, 1);
                chk("R6 we_n refresh", we_n, 1);
                chk("R6 dir refresh", dir, 0);
                chk("R7 rom_sel_n refresh", rom_sel_n, 1);
            end else begin
                chk("R2 ma", ma, (s <= 4) ? ((a >> 11) & 'h7FF) : (a & 'h7FF));
                chk("R3 ras_n", ras_n, (s <= 4) ? 0 : 1);
                chk(rg == 1 ? "R5 cas_n" : "R4 cas_n", cas_n, (dram && s >= 5 && s <= 7) ? 0 : 1);
                chk("R8 oe_n", oe_n, (dram && !w && s >= 5) ? 0 : 1);
                chk("R9 we_n", we_n, (w && s >= 5) ? 0 : 1);
                chk("R9 dir", dir, w);
                chk("R7 rom_sel_n", rom_sel_n, (s <= 3) ? ((rg == 1 && !w) ? 0 : 1) : ((a >> 13) & 1));
                chk("R6 refresh flag access", refresh, 0);
            end
            chk("R1 done", done, (s == 15) ? 1 : 0);
            chk("R1 ready", req_ready, (s == 15) ? 1 : 0);
            if (s < 15) @(negedge clk);
        end
        if (r) refc = (refc + 1) & 'hFF;
    endtask

    task automatic gap();
        @(posedge clk);
        @(negedge clk);
        check_idle("gap");
    endtask

    initial begin
        #(100000 * 10);
        if (!ended) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int corners [8] = '{'h000000, 'h00000F, 'h000010, 'h00FFFF,
                            'h010000, 'h1EFFFF, 'h1F0000, 'h1FFFFF};
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 bus_rst_n in reset", bus_rst_n, 0);
        check_idle("reset");
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R10 bus_rst_n after reset", bus_rst_n, 1);
        check_idle("after reset");

        // R10: software reset
        sw_reset = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R10 bus_rst_n sw low", bus_rst_n, 0);
        sw_reset = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R10 bus_rst_n sw release", bus_rst_n, 1);

        // directed: each region edge, both boot flags, read and write
        foreach (corners[i]) begin
            run_cycle(corners[i], 1'b0, 1'b0, 1'b0);
            run_cycle(corners[i], 1'b1, 1'b0, 1'b0);
            run_cycle(corners[i], 1'b0, 1'b0, 1'b1);
        end
        gap();
        // R6: refresh with junk fields, counter stepping
        run_cycle('h1F2345, 1'b1, 1'b1, 1'b0);
        run_cycle('h000000, 1'b0, 1'b1, 1'b1);
        run_cycle('h0ABCDE, 1'b1, 1'b0, 1'b1);
        run_cycle('h000003, 1'b0, 1'b1, 1'b0);
        gap();

        // random mix
        for (int n = 0; n < 60; n++) begin
            int  a;
            bit  r;
            r = ($urandom % 5) == 0;
            a = ($urandom % 3 == 0) ? corners[$urandom % 8] : int'($urandom & 'h1FFFFF);
            run_cycle(a, bit'($urandom), r, bit'($urandom));
            if ($urandom % 4 == 0) gap();
        end
        gap();

        ended = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule